// File: doc/BRIEF.md
# Cache Block Zeroing Engine

This engine clears one naturally aligned block of memory on behalf of a cache-block zero instruction. A request brings the source register address, the block-size exponent (block size is 2^exp bytes, exp up to 12, a 4 KiB page; software platforms commonly use 6) and the outcome of the privilege enable evaluation done elsewhere. Decode has already matched the instruction (major opcode 0001111, funct3 010, rd zero, immediate field 0x004). Address translation is outside the block, so the physical address is the aligned address.

An enabled request is turned into a run of word-wide zero writes on a valid/ready write port. The writes start at the block base and go upward. An error flagged by memory during a handshake stops the run and reports a fault with the failing address. A request whose enable check failed produces an illegal-instruction pulse and touches no memory. Any byte order and granularity is allowed for this operation, which is what permits the word-by-word form.

Top module: `blkzero_engine`

## Requirements
- R1: After reset, busy, wr_valid, done, fault and illegal are all low.
- R2: A request taken while idle with req_enabled low gives one illegal pulse in the next cycle, issues no write and leaves busy low.
- R3: The block base is req_addr with its low e bits cleared, where e is req_exp clamped to 12; an exponent above 12 behaves as 12.
- R4: For e >= 2 (4-byte words), exactly 2^e/4 writes are issued at base, base+4, base+8 and so on in ascending order, each with wr_strb = 4'b1111.
- R5: For e < 2, a single write is issued at the word address base & ~3, with wr_strb bit k set for lanes k = base[1:0] up to base[1:0] + 2^e - 1.
- R6: wr_data is zero on every write.
- R7: While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_strb hold their values.
- R8: One cycle after the final write is accepted without error, done pulses for one cycle and busy is low in that same cycle.
- R9: When a write handshake carries wr_err high, the next cycle shows a fault pulse with fault_addr equal to that write's address, and no further write is issued.
- R10: A request presented while busy is ignored: it neither changes the running sequence nor starts a later one, nor yields an illegal pulse.
- R11: busy is high from the cycle after an enabled request is taken until the cycle done or fault pulses; at most one of done, fault and illegal is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | ADDR_W | Source register address |
| req_exp | input | EXP_W | Block-size exponent |
| req_enabled | input | 1 | Result of the privilege enable check |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: block cleared |
| fault | output | 1 | One-cycle pulse: memory error ended the run |
| illegal | output | 1 | One-cycle pulse: request was not enabled |
| fault_addr | output | ADDR_W | Address of the write that failed |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write this cycle |
| wr_err | input | 1 | Error response for the write being accepted |
| wr_addr | output | ADDR_W | Word-aligned byte address of the write |
| wr_data | output | DATA_W | Write data (always zero) |
| wr_strb | output | DATA_W/8 | Byte lane enables |

## Verification
The hardest condition to reach is an error in the middle of a long block while memory stalls at irregular intervals. Only then does the stop-on-fault path meet a held write and a counter partway through its range. The bench sweeps every exponent from 0 to 13 over unaligned addresses under three ready patterns. It then injects the error on a chosen write index inside a 64-byte block under a stalling pattern. A stray request is also pushed into the middle of a running sequence, so the ignore rule is seen against live traffic.

// File: rtl/blkzero_pkg.sv
package blkzero_pkg;
    typedef enum logic {
        BZ_IDLE  = 1'b0,
        BZ_WRITE = 1'b1
    } bz_state_e;
endpackage

// File: rtl/blkzero_span.sv
// Turns an address and exponent into the block's first word, word count and lane mask.
module blkzero_span #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int MAX_EXP = 12,
    localparam int WB     = DATA_W / 8,
    localparam int OFF_W  = $clog2(WB),
    localparam int EXP_W  = $clog2(MAX_EXP + 1),
    localparam int CNT_W  = MAX_EXP - OFF_W + 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [EXP_W-1:0]  exp_i,
    output logic [ADDR_W-1:0] base_word_o,
    output logic [CNT_W-1:0]  last_o,
    output logic [WB-1:0]     strb_o
);
    logic [EXP_W-1:0]  e_c;
    logic [ADDR_W-1:0] base;
    int                ei;

    always_comb begin
        // R3: clamp oversized exponents to the page limit
        e_c  = (exp_i > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_i;
        ei   = int'(e_c);
        base = addr_i & ({ADDR_W{1'b1}} << e_c);
        base_word_o = base & ~ADDR_W'(WB - 1);
        if (ei >= OFF_W) begin
            last_o = CNT_W'((1 << (ei - OFF_W)) - 1);
            strb_o = '1;
        end else begin
            last_o = '0;
            strb_o = WB'((1 << (1 << ei)) - 1) << base[OFF_W-1:0];
        end
    end
endmodule

// File: rtl/blkzero_seq.sv
// Request acceptance and the write sequence with its result pulses.
module blkzero_seq
    import blkzero_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WB     = 4,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_enabled,
    input  logic [ADDR_W-1:0] base_word,
    input  logic [CNT_W-1:0]  last_idx,
    input  logic [WB-1:0]     lane_mask,
    input  logic              wr_ready,
    input  logic              wr_err,
    output logic              busy,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WB-1:0]     wr_strb,
    output logic              done,
    output logic              fault,
    output logic              illegal,
    output logic [ADDR_W-1:0] fault_addr
);
    typedef struct packed {
        bz_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
        logic [WB-1:0]     strb;
        logic              done;
        logic              fault;
        logic              illegal;
        logic [ADDR_W-1:0] faddr;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.fault   = 1'b0;
        d.illegal = 1'b0;
        unique case (q.st)
            BZ_IDLE: begin
                if (req_valid && req_enabled) begin
                    d.st   = BZ_WRITE;
                    d.addr = base_word;
                    d.left = last_idx;
                    d.strb = lane_mask;
                end else if (req_valid) begin
                    d.illegal = 1'b1;
                end
            end
            BZ_WRITE: begin
                if (wr_ready) begin
                    if (wr_err) begin
                        d.fault = 1'b1;
                        d.faddr = q.addr;
                        d.st    = BZ_IDLE;
                    end else if (q.left == '0) begin
                        d.done = 1'b1;
                        d.st   = BZ_IDLE;
                    end else begin
                        d.addr = q.addr + ADDR_W'(WB);
                        d.left = q.left - 1'b1;
                    end
                end
            end
            default: d.st = BZ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: BZ_IDLE, default: '0};
        else        q <= d;
    end

    assign busy       = (q.st == BZ_WRITE);
    assign wr_valid   = (q.st == BZ_WRITE);
    assign wr_addr    = q.addr;
    assign wr_strb    = q.strb;
    assign done       = q.done;
    assign fault      = q.fault;
    assign illegal    = q.illegal;
    assign fault_addr = q.faddr;

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_strb));
    // R4
    ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && !wr_err && q.left != '0
        |=> wr_valid && wr_addr == $past(wr_addr) + ADDR_W'(WB));
    // R9
    fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && wr_err
        |=> fault && !wr_valid && fault_addr == $past(wr_addr));
    // R8
    done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && !wr_err && q.left == '0 |=> done && !busy);
    // R2
    illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy && !req_enabled |=> illegal && !wr_valid);
    // R11
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault, illegal}));
endmodule

// File: rtl/blkzero_engine.sv
module blkzero_engine #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int MAX_EXP = 12,
    localparam int WB     = DATA_W / 8,
    localparam int OFF_W  = $clog2(WB),
    localparam int EXP_W  = $clog2(MAX_EXP + 1),
    localparam int CNT_W  = MAX_EXP - OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [EXP_W-1:0]  req_exp,
    input  logic              req_enabled,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic              illegal,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              wr_valid,
    input  logic              wr_ready,
    input  logic              wr_err,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [WB-1:0]     wr_strb
);
    logic [ADDR_W-1:0] base_word;
    logic [CNT_W-1:0]  last_idx;
    logic [WB-1:0]     lane_mask;

    blkzero_span #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_EXP(MAX_EXP)) u_span (
        .addr_i      (req_addr),
        .exp_i       (req_exp),
        .base_word_o (base_word),
        .last_o      (last_idx),
        .strb_o      (lane_mask)
    );

    blkzero_seq #(.ADDR_W(ADDR_W), .WB(WB), .CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_enabled (req_enabled),
        .base_word   (base_word),
        .last_idx    (last_idx),
        .lane_mask   (lane_mask),
        .wr_ready    (wr_ready),
        .wr_err      (wr_err),
        .busy        (busy),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_strb     (wr_strb),
        .done        (done),
        .fault       (fault),
        .illegal     (illegal),
        .fault_addr  (fault_addr)
    );

    // R6: the engine only ever clears memory
    assign wr_data = '0;

    // R5
    lane_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_strb != '0 && wr_addr[OFF_W-1:0] == '0);
    // R11
    busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !$past(busy) |-> $past(req_valid) && $past(req_enabled));
endmodule

// File: tb/tb_blkzero_engine.sv
module tb_blkzero_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_exp = '0;
    logic        req_enabled = 1'b0;
    logic        busy, done, fault, illegal, wr_valid;
    logic        wr_ready = 1'b0;
    logic        wr_err = 1'b0;
    logic [31:0] fault_addr, wr_addr, wr_data;
    logic [3:0]  wr_strb;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit summary_done = 1'b0;

    always #2.5 clk = ~clk;

    blkzero_engine dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_exp(req_exp), .req_enabled(req_enabled), .busy(busy), .done(done),
        .fault(fault), .illegal(illegal), .fault_addr(fault_addr),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_err(wr_err),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
    );

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic bit ready_at(input int mode, input int cyc);
        case (mode)
            0: return 1'b1;
            1: return (cyc % 3) == 2;
            default: return ((cyc * 7 + 3) % 5) < 2;
        endcase
    endfunction

    // One operation: expected behaviour computed from R3, R4, R5
    task automatic run_op(input logic [31:0] a, input int ex, input int mode,
                          input int err_at, input bit stray);
        int e = (ex > 12) ? 12 : ex;
        int unsigned size = 1 << e;
        logic [31:0] base = a & ~(size - 1);
        int nwords = (e >= 2) ? (size / 4) : 1;
        logic [3:0] xstrb = (e >= 2) ? 4'hF : 4'(((1 << size) - 1) << base[1:0]);
        logic [31:0] wbase = base & ~32'd3;
        int idx = 0;
        int cyc = 0;
        bit finished = 1'b0;
        bit rdy, hs, saw_illegal;
        saw_illegal = 1'b0;
        req_valid = 1'b1; req_addr = a; req_exp = 4'(ex); req_enabled = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R11 busy after accept", busy, 1);
        while (!finished && cyc < 6000) begin
            if (stray && cyc == 1) begin
                req_valid = 1'b1; req_addr = a ^ 32'h0001_0000; req_exp = 4'd0;
                req_enabled = (mode == 1);
            end else begin
                req_valid = 1'b0;
            end
            rdy = ready_at(mode, cyc);
            wr_ready = rdy;
            wr_err = rdy && (idx == err_at);
            hs = wr_valid && rdy;
            if (wr_valid) begin
                chk(wr_addr === wbase + 32'(4 * idx), hs ? "R4 address" : "R7 held address",
                    wr_addr, wbase + 32'(4 * idx));
                chk(wr_strb === xstrb, e >= 2 ? "R4 strobe" : "R5 strobe", wr_strb, xstrb);
                if (hs) chk(wr_data === 32'h0, "R6 zero data", wr_data, 0);
            end else begin
                chk(1'b0, "R11 wr_valid while busy", 0, 1);
            end
            @(posedge clk); @(negedge clk);
            if (illegal) saw_illegal = 1'b1;
            if (hs) begin
                if (idx == err_at) begin
                    chk(fault === 1'b1 && busy === 1'b0, "R9 fault pulse", fault, 1);
                    chk(fault_addr === wbase + 32'(4 * idx), "R9 fault address",
                        fault_addr, wbase + 32'(4 * idx));
                    finished = 1'b1;
                end else begin
                    idx++;
                    if (idx == nwords) begin
                        chk(done === 1'b1 && busy === 1'b0, "R8 done pulse", done, 1);
                        finished = 1'b1;
                    end else begin
                        chk(done === 1'b0 && busy === 1'b1, "R11 busy mid-run", busy, 1);
                    end
                end
            end
            cyc++;
        end
        req_valid = 1'b0; wr_ready = 1'b1; wr_err = 1'b0;
        chk(finished, "R4 sequence finished", finished, 1);
        @(posedge clk); @(negedge clk);
        chk(wr_valid === 1'b0 && busy === 1'b0 && done === 1'b0 && fault === 1'b0,
            err_at >= 0 ? "R9 no write after fault" : "R10 idle after run", wr_valid, 0);
        if (stray) chk(!saw_illegal && illegal === 1'b0, "R10 stray gave no illegal", saw_illegal, 0);
        wr_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 0 && wr_valid === 0 && done === 0 && fault === 0 && illegal === 0,
            "R1 reset outputs", {busy, wr_valid, done, fault, illegal}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: disabled request
        req_valid = 1'b1; req_addr = 32'h0000_1234; req_exp = 4'd6; req_enabled = 1'b0;
        wr_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk(illegal === 1'b1 && busy === 1'b0 && wr_valid === 1'b0, "R2 illegal pulse",
            {illegal, busy, wr_valid}, 3'b100);
        @(posedge clk); @(negedge clk);
        chk(illegal === 1'b0 && wr_valid === 1'b0, "R2 single pulse, no write",
            {illegal, wr_valid}, 0);
        wr_ready = 1'b0;

        // R3 R4 R5: sweep every exponent, including one above the limit
        for (int ex = 0; ex <= 13; ex++)
            for (int m = 0; m < 3; m++) begin
                run_op(32'h0003_5A37, ex, m, -1, 1'b0);
                run_op(32'h8000_0002 + 32'(ex), ex, m, -1, 1'b0);
                run_op(32'hFFFF_FFFD, ex, m, -1, 1'b0);
            end

        // R9: errors at first, middle and last write of a 64-byte block
        run_op(32'h0000_4321, 6, 1, 0, 1'b0);
        run_op(32'h0000_4321, 6, 2, 5, 1'b0);
        run_op(32'h0000_4321, 6, 1, 15, 1'b0);
        run_op(32'h0000_0003, 1, 0, 0, 1'b0);

        // R10: stray enabled and disabled requests while busy
        run_op(32'h0000_7788, 5, 1, -1, 1'b1);
        run_op(32'h0000_7788, 5, 2, -1, 1'b1);

        summary();
        $finish;
    end
endmodule